// File: doc/BRIEF.md
# SPI Channel Transmit/Receive Event Flag Generator

This block turns the data-path state of one SPI peripheral channel into four sticky event flags and one interrupt request. It watches the CPU's write strobe to the transmit data register, the CPU's read strobe from the receive data register, the receive shift path delivering a word, the occupancy of the transmit and receive FIFOs, and the moment an external master begins a transfer in slave mode. From these it raises transmit-empty, transmit-underflow, receive-full and receive-overflow. Each flag stays set until software writes a one to it, and a per-flag enable decides whether it drives the interrupt line.

Each direction can run in one of two modes. In direct mode the flags follow a single register's full/empty state. In FIFO mode a flag fires when a programmable byte threshold is crossed. After it fires, the flag is disarmed until the CPU has made the agreed number of accesses. Transmit-underflow is held off after the channel is enabled until the CPU has written data at least once, so the first transfer does not raise a false warning. Dropping the channel enable returns all flags, counters and the first-write memory to their idle values.

Top module: `spi_evt_gen`

## Requirements
- R1: While the channel enable is low, all four status bits are 0 one cycle later and the interrupt line is low.
- R2: In direct transmit mode, an enabled channel whose transmit register holds no data sets status bit 0 (transmit-empty). Enabling the channel therefore sets it one cycle later.
- R3: Status bit 1 (transmit-underflow) is not set by a transfer start unless the CPU has written the transmit register at least once since the channel was last enabled.
- R4: After such a write, a transfer start that finds the transmit register empty (direct mode) or the transmit FIFO at level 0 (FIFO mode) sets status bit 1 one cycle later.
- R5: In transmit FIFO mode, while armed, status bit 0 is set once the free space (DEPTH minus the transmit level) is at least the 6-bit almost-empty threshold. Below that it stays clear.
- R6: After a FIFO-mode transmit-empty event, transmit-empty is disarmed until threshold+1 CPU writes have been made. It fires again in the cycle after the last of those writes.
- R7: In receive FIFO mode, while armed, status bit 2 (receive-full) is set once the receive level is at least the 6-bit almost-full threshold.
- R8: After a FIFO-mode receive-full event, receive-full is disarmed until threshold+1 CPU reads have been made. It fires again in the cycle after the last read.
- R9: In direct receive mode, a word delivered by the shift path sets status bit 2 on the second clock edge after the delivery strobe. The flag is no longer raised once the CPU has read the word.
- R10: Only on the channel with index 0, a delivery into a full receive register (or into a FIFO at DEPTH) sets status bit 3 (receive-overflow). On other channels bit 3 stays 0.
- R11: Status bits are sticky and cleared by writing 1 to the matching clear bit. An event in the same cycle as its clear wins.
- R12: The interrupt line is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| tx_fifo_en | input | 1 | Transmit path uses the FIFO |
| rx_fifo_en | input | 1 | Receive path uses the FIFO |
| ael | input | 6 | Transmit almost-empty threshold in bytes |
| afl | input | 6 | Receive almost-full threshold in bytes |
| tx_wr | input | 1 | CPU write to transmit data register |
| rx_rd | input | 1 | CPU read of receive data register |
| rx_load | input | 1 | Shift path delivers a received word |
| xfer_start | input | 1 | External master starts a transfer |
| tx_level | input | 6 | Transmit FIFO occupancy in bytes |
| rx_level | input | 6 | Receive FIFO occupancy in bytes |
| clr | input | 4 | Write-1-to-clear strobes, one per status bit |
| ien | input | 4 | Interrupt enables, one per status bit |
| status | output | 4 | Sticky status: 0 tx-empty, 1 tx-underflow, 2 rx-full, 3 rx-overflow |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the underflow suppression window. A design that forgot the first-write memory would warn on the very first transfer after enabling. One that never cleared it on disable would warn after a re-enable. It counts the rearm accesses exactly, checking that threshold writes or reads leave the event disarmed and that one more brings it back. An off-by-one counter would fire one access early or late. It also clears a flag while its direct-mode source is still present, confirming the flag reappears. It then checks that overflow appears only on channel 0, which catches a design that leaks the bit onto other channels.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
    localparam int EV_TXE = 0;
    localparam int EV_UDF = 1;
    localparam int EV_RXF = 2;
    localparam int EV_OVF = 3;
    localparam int EV_N   = 4;

    typedef logic [EV_N-1:0] ev_vec_t;
endpackage

// File: rtl/spi_evt_tx.sv
module spi_evt_tx #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] ael,
    input  logic             tx_wr,
    input  logic             xfer_start,
    input  logic [OCC_W-1:0] tx_level,
    output logic             ev_empty,
    output logic             ev_udf
);
    localparam int CMP_W = ((OCC_W > LVL_W) ? OCC_W : LVL_W) + 1;

    typedef struct packed {
        logic           reg_full;
        logic           first_wr;
        logic           armed;
        logic [LVL_W:0] wr_cnt;
    } tx_st_t;

    localparam tx_st_t TX_IDLE = '{reg_full: 1'b0, first_wr: 1'b0, armed: 1'b1, wr_cnt: '0};

    tx_st_t     st_d, st_q;
    logic [CMP_W-1:0] free_sp;
    logic             empty_now;

    always_comb begin
        free_sp   = CMP_W'(DEPTH) - CMP_W'(tx_level);
        empty_now = fifo_en ? (tx_level == '0) : !st_q.reg_full;
        ev_empty  = chan_en && (fifo_en ? (st_q.armed && (free_sp >= CMP_W'(ael)))
                                        : !st_q.reg_full);
        ev_udf    = chan_en && xfer_start && st_q.first_wr && empty_now;

        st_d = st_q;
        if (!chan_en) begin
            st_d = TX_IDLE;
        end else begin
            st_d.reg_full = (st_q.reg_full && !xfer_start) || tx_wr;
            if (tx_wr) begin
                st_d.first_wr = 1'b1;
            end
            if (fifo_en) begin
                if (ev_empty) begin
                    st_d.armed  = 1'b0;
                    st_d.wr_cnt = '0;
                end else if (!st_q.armed && tx_wr) begin
                    if (st_q.wr_cnt == {1'b0, ael}) begin
                        st_d.armed  = 1'b1;
                        st_d.wr_cnt = '0;
                    end else begin
                        st_d.wr_cnt = st_q.wr_cnt + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // R6: a disarmed transmit-empty only leaves that state through a CPU write
    p_tx_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && fifo_en && !st_q.armed && !tx_wr) |=> !st_q.armed);

    // R3: the first-write memory is forgotten whenever the channel is off
    p_first_wr_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !st_q.first_wr);
endmodule

// File: rtl/spi_evt_rx.sv
module spi_evt_rx #(
    parameter int DEPTH   = 32,
    parameter int LVL_W   = 6,
    parameter int OCC_W   = $clog2(DEPTH + 1),
    parameter bit HAS_OVF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] afl,
    input  logic             rx_rd,
    input  logic             rx_load,
    input  logic [OCC_W-1:0] rx_level,
    output logic             ev_full,
    output logic             ev_ovf
);
    localparam int CMP_W = ((OCC_W > LVL_W) ? OCC_W : LVL_W) + 1;

    typedef struct packed {
        logic           reg_full;
        logic           armed;
        logic [LVL_W:0] rd_cnt;
    } rx_st_t;

    localparam rx_st_t RX_IDLE = '{reg_full: 1'b0, armed: 1'b1, rd_cnt: '0};

    rx_st_t st_d, st_q;

    always_comb begin
        ev_full = chan_en && (fifo_en ? (st_q.armed && (CMP_W'(rx_level) >= CMP_W'(afl)))
                                      : st_q.reg_full);
        st_d = st_q;
        if (!chan_en) begin
            st_d = RX_IDLE;
        end else begin
            st_d.reg_full = (st_q.reg_full && !rx_rd) || rx_load;
            if (fifo_en) begin
                if (ev_full) begin
                    st_d.armed  = 1'b0;
                    st_d.rd_cnt = '0;
                end else if (!st_q.armed && rx_rd) begin
                    if (st_q.rd_cnt == {1'b0, afl}) begin
                        st_d.armed  = 1'b1;
                        st_d.rd_cnt = '0;
                    end else begin
                        st_d.rd_cnt = st_q.rd_cnt + 1'b1;
                    end
                end
            end
        end
    end

    generate
        if (HAS_OVF) begin : g_ovf
            always_comb begin
                ev_ovf = chan_en && rx_load &&
                         (fifo_en ? (rx_level == OCC_W'(DEPTH))
                                  : (st_q.reg_full && !rx_rd));
            end
            // R10: an overflow event always coincides with a word delivery
            p_ovf_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ev_ovf |-> rx_load);
        end else begin : g_no_ovf
            always_comb ev_ovf = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // R8: a disarmed receive-full only leaves that state through a CPU read
    p_rx_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && fifo_en && !st_q.armed && !rx_rd) |=> !st_q.armed);
endmodule

// File: rtl/spi_evt_stat.sv
module spi_evt_stat
    import spi_evt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    chan_en,
    input  ev_vec_t ev,
    input  ev_vec_t clr,
    input  ev_vec_t ien,
    output ev_vec_t status,
    output logic    irq
);
    typedef struct packed {
        ev_vec_t flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!chan_en) st_d.flags = '0;
        else          st_d.flags = (st_q.flags & ~clr) | ev;
        status = st_q.flags;
        irq    = |(st_q.flags & ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a flag not written with 1 survives while the channel stays on
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && $past(chan_en)) |-> (($past(st_q.flags) & ~$past(clr) & ~st_q.flags) == '0));

    // R1: a disabled channel shows no flags on the next cycle
    p_dis_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (st_q.flags == '0));
endmodule

// File: rtl/spi_evt_gen.sv
module spi_evt_gen
    import spi_evt_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6,
    parameter int CH_ID = 0,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             tx_fifo_en,
    input  logic             rx_fifo_en,
    input  logic [LVL_W-1:0] ael,
    input  logic [LVL_W-1:0] afl,
    input  logic             tx_wr,
    input  logic             rx_rd,
    input  logic             rx_load,
    input  logic             xfer_start,
    input  logic [OCC_W-1:0] tx_level,
    input  logic [OCC_W-1:0] rx_level,
    input  logic [EV_N-1:0]  clr,
    input  logic [EV_N-1:0]  ien,
    output logic [EV_N-1:0]  status,
    output logic             irq
);
    localparam bit HAS_OVF = (CH_ID == 0);

    ev_vec_t ev;
    logic    ev_txe, ev_udf, ev_rxf, ev_ovf;

    spi_evt_tx #(.DEPTH(DEPTH), .LVL_W(LVL_W), .OCC_W(OCC_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .fifo_en(tx_fifo_en),
        .ael(ael), .tx_wr(tx_wr), .xfer_start(xfer_start), .tx_level(tx_level),
        .ev_empty(ev_txe), .ev_udf(ev_udf)
    );

    spi_evt_rx #(.DEPTH(DEPTH), .LVL_W(LVL_W), .OCC_W(OCC_W), .HAS_OVF(HAS_OVF)) u_rx (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .fifo_en(rx_fifo_en),
        .afl(afl), .rx_rd(rx_rd), .rx_load(rx_load), .rx_level(rx_level),
        .ev_full(ev_rxf), .ev_ovf(ev_ovf)
    );

    always_comb begin
        ev         = '0;
        ev[EV_TXE] = ev_txe;
        ev[EV_UDF] = ev_udf;
        ev[EV_RXF] = ev_rxf;
        ev[EV_OVF] = ev_ovf;
    end

    spi_evt_stat u_stat (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ev(ev),
        .clr(clr), .ien(ien), .status(status), .irq(irq)
    );

    // R4: an underflow flag only appears right after a transfer start
    p_udf_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[EV_UDF]) |-> $past(xfer_start));

    // R12: a quiet interrupt line means no enabled flag is set
    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> ((status & ien) == '0));
endmodule

// File: tb/sim_spi_evt_gen.sv
module sim_spi_evt_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0, tx_fifo_en = 1'b0, rx_fifo_en = 1'b0;
    logic [5:0] ael = '0, afl = '0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, rx_load = 1'b0, xfer_start = 1'b0;
    logic [5:0] tx_level = '0, rx_level = '0;
    logic [3:0] clr = '0, ien = '0;
    logic [3:0] status, status1;
    logic       irq, irq1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_evt_gen #(.CH_ID(0)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tx_fifo_en(tx_fifo_en),
        .rx_fifo_en(rx_fifo_en), .ael(ael), .afl(afl), .tx_wr(tx_wr), .rx_rd(rx_rd),
        .rx_load(rx_load), .xfer_start(xfer_start), .tx_level(tx_level),
        .rx_level(rx_level), .clr(clr), .ien(ien), .status(status), .irq(irq)
    );

    spi_evt_gen #(.CH_ID(1)) u1 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tx_fifo_en(tx_fifo_en),
        .rx_fifo_en(rx_fifo_en), .ael(ael), .afl(afl), .tx_wr(tx_wr), .rx_rd(rx_rd),
        .rx_load(rx_load), .xfer_start(xfer_start), .tx_level(tx_level),
        .rx_level(rx_level), .clr(clr), .ien(ien), .status(status1), .irq(irq1)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic restart();
        chan_en = 1'b0; clr = '0; tx_wr = 0; rx_rd = 0; rx_load = 0; xfer_start = 0;
        step();
    endtask

    task automatic t_reset();
        check("R1 status after reset", |status, 1'b0);
        check("R1 irq after reset", irq, 1'b0);
    endtask

    task automatic t_direct_tx();
        restart();
        tx_fifo_en = 0; ien = 4'hF;
        chan_en = 1; step();
        check("R2 tx-empty on enable", status[0], 1'b1);
        check("R12 irq with enabled flag", irq, 1'b1);
        clr = 4'b0001; step(); clr = '0;
        check("R11 source still present re-sets", status[0], 1'b1);
        tx_wr = 1; step(); tx_wr = 0;
        clr = 4'b0001; step(); clr = '0;
        check("R11 write-1 clears", status[0], 1'b0);
    endtask

    task automatic t_underflow();
        restart();
        tx_fifo_en = 0; ien = 4'hF;
        chan_en = 1; step();
        xfer_start = 1; step(); xfer_start = 0;
        check("R3 no underflow before first write", status[1], 1'b0);
        tx_wr = 1; step(); tx_wr = 0;
        xfer_start = 1; step();
        check("R4 no underflow with data present", status[1], 1'b0);
        step(); xfer_start = 0;
        check("R4 underflow on empty register", status[1], 1'b1);
        step(); step();
        check("R11 underflow sticky", status[1], 1'b1);
        ien = 4'b0000; #1;
        check("R12 irq masked", irq, 1'b0);
        ien = 4'b0010; #1;
        check("R12 irq from underflow alone", irq, 1'b1);
        clr = 4'b0010; step(); clr = '0;
        check("R11 underflow cleared", status[1], 1'b0);
        restart();
        chan_en = 1; step();
        xfer_start = 1; step(); xfer_start = 0;
        check("R3 suppression restored after re-enable", status[1], 1'b0);
    endtask

    task automatic t_fifo_tx();
        restart();
        tx_fifo_en = 1; ael = 6'd8; tx_level = 6'd30; ien = 4'hF;
        chan_en = 1; step();
        check("R5 free space below threshold", status[0], 1'b0);
        tx_level = 6'd24; step();
        check("R5 free space reaches threshold", status[0], 1'b1);
        clr = 4'b0001; step(); clr = '0;
        check("R6 disarmed after event", status[0], 1'b0);
        for (int i = 0; i < 8; i++) begin
            tx_wr = 1; step();
        end
        tx_wr = 0; step();
        check("R6 threshold writes not enough", status[0], 1'b0);
        tx_wr = 1; step(); tx_wr = 0; step();
        check("R6 rearmed after threshold+1 writes", status[0], 1'b1);
        tx_level = 6'd0; clr = 4'b0010; step(); clr = '0;
        xfer_start = 1; step(); xfer_start = 0;
        check("R4 underflow with empty FIFO", status[1], 1'b1);
    endtask

    task automatic t_fifo_rx();
        restart();
        rx_fifo_en = 1; afl = 6'd4; rx_level = 6'd3; ien = 4'hF;
        chan_en = 1; step();
        check("R7 level below threshold", status[2], 1'b0);
        rx_level = 6'd4; step();
        check("R7 level reaches threshold", status[2], 1'b1);
        clr = 4'b0100; step(); clr = '0;
        check("R8 disarmed after event", status[2], 1'b0);
        for (int i = 0; i < 4; i++) begin
            rx_rd = 1; step();
        end
        rx_rd = 0; step();
        check("R8 threshold reads not enough", status[2], 1'b0);
        rx_rd = 1; step(); rx_rd = 0; step();
        check("R8 rearmed after threshold+1 reads", status[2], 1'b1);
    endtask

    task automatic t_direct_rx();
        restart();
        rx_fifo_en = 0; ien = 4'hF;
        chan_en = 1; step();
        rx_load = 1; step(); rx_load = 0;
        check("R9 not yet set after one edge", status[2], 1'b0);
        step();
        check("R9 rx-full after delivery", status[2], 1'b1);
        rx_load = 1; step(); rx_load = 0;
        check("R10 overflow on channel 0", status[3], 1'b1);
        check("R10 no overflow on channel 1", status1[3], 1'b0);
        rx_rd = 1; step(); rx_rd = 0;
        clr = 4'b0100; step(); clr = '0;
        check("R9 rx-full gone after read", status[2], 1'b0);
        chan_en = 0; step();
        check("R1 disable clears status", |status, 1'b0);
        check("R1 disable drops irq", irq, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_direct_tx();
        t_underflow();
        t_fifo_tx();
        t_fifo_rx();
        t_direct_rx();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule